// File: doc/BRIEF.md
# VLAN table command engine

This block keeps a switch's VLAN membership table and changes it only when a host issues a command through a small synchronous register port. Each table entry holds a 13-bit VLAN ID, a 2-bit member tag for each port and a forwarding database number. The host first sets up the ID and the per-port data registers. It then writes the command register with the start bit set and polls that bit until it drops.

Four commands exist. The store command adds, replaces or removes the entry for one VLAN ID. The walk command finds the next higher valid ID and leaves it in the ID register, so the host can issue it again to visit the whole table. The clear command empties the table. A violation command code is reserved and completes with no effect. Lookups scan the table one slot per clock, so a store or walk takes a fixed number of cycles.

Top module: `vlan_tbl_engine`

## Requirements
- R1: Register addresses: 0 command, 1 ID, 2 to 4 data words 0 to 2. Reads return the addressed register one clock after the address is presented. Command register bit 15 is the start/busy flag and bits 14:12 are the command code (1 clear, 3 store, 4 walk, others finish with no effect). Writing the command register with bit 15 set starts the command. Bit 15 then reads 1 until the command ends and returns to 0 without a host write. All registers read zero after reset.
- R2: While bit 15 is set, host writes to every register are ignored, including a second command write.
- R3: ID register layout: bits 11:0 hold ID bits 11:0, bit 12 holds ID bit 12 and bit 15 is the valid flag. The walk command looks for the smallest valid ID strictly greater than the 13-bit ID in the register. When it finds one, it writes that ID back with valid set and loads the entry's member tags and database number.
- R4: If no valid ID is higher than the key, the walk command clears the valid flag and leaves ID bits 12:0 unchanged.
- R5: Repeating the walk command with no new ID write returns the following entry each time. A walk that starts from key 0 visits every stored entry other than ID 0, in ascending order.
- R6: A store command with the valid flag set writes the entry. An existing entry with the same ID is replaced and does not take a second slot.
- R7: A store command with the valid flag clear removes the entry for that ID. If no such entry exists, the table is unchanged.
- R8: Per-port data is packed four ports to a data word. Port i uses bits (i mod 4)*4+1:(i mod 4)*4 of data word i/4 for its member tag, and the two bits above for a port state. Port state bits are not stored, and a walk returns them as zero.
- R9: The database number is taken from command bits 3:0 (low nibble) and 11:8 (high nibble) on a store. A walk that finds an entry returns the number in the same positions.
- R10: The clear command invalidates every entry.
- R11: A store of a new ID when all DEPTH slots are valid has no effect.
- R12: Busy lasts DEPTH+2 cycles for a store, DEPTH+3 cycles for a walk and 1 cycle for a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |

## Verification
The assertions assume that the host never changes the ID key while a command runs. The design enforces this by ignoring writes while busy, and the bench also tests that lock on purpose. The assertions also assume that every reset pulse lasts at least one clock. The bench only starts a new command after it has seen the busy flag low. It keeps the number of distinct IDs within DEPTH, apart from the one deliberate overflow store. Expected results come from a model indexed by ID that the bench keeps itself.

// File: rtl/vtbl_pkg.sv
package vtbl_pkg;
  localparam int REG_W = 16;
  localparam int VID_W = 13;
  localparam int NUM_DREG = 3;

  localparam logic [2:0] ADR_CMD = 3'd0;
  localparam logic [2:0] ADR_ID  = 3'd1;
  localparam logic [2:0] ADR_D0  = 3'd2;
  localparam logic [2:0] ADR_D1  = 3'd3;
  localparam logic [2:0] ADR_D2  = 3'd4;

  localparam logic [2:0] CODE_CLEAR = 3'd1;
  localparam logic [2:0] CODE_STORE = 3'd3;
  localparam logic [2:0] CODE_WALK  = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SCAN, ST_DRAIN, ST_FETCH, ST_COMMIT
  } eng_st_e;
endpackage

// File: rtl/vtbl_store.sv
module vtbl_store #(
  parameter int DEPTH = 64,
  parameter int ENT_W = 41,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [ENT_W-1:0] rd_ent,
  output logic             rd_vld,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [ENT_W-1:0] wr_ent,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_addr,
  input  logic             flush
);
  logic [ENT_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0] vld_q;

  // payload: plain synchronous RAM, no reset
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_ent;
    rd_ent <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      rd_vld <= 1'b0;
    end else begin
      rd_vld <= vld_q[rd_addr];
      if (flush)       vld_q <= '0;
      else if (wr_en)  vld_q[wr_addr] <= 1'b1;
      else if (clr_en) vld_q[clr_addr] <= 1'b0;
    end
  end

  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (vld_q == '0));
  assert_write_marks_valid_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flush) |=> vld_q[$past(wr_addr)]);
  assert_remove_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !wr_en && !flush) |=> !vld_q[$past(clr_addr)]);
endmodule

// File: rtl/vtbl_match.sv
module vtbl_match #(
  parameter int IDX_W = 6,
  parameter int VID_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             cmp_en,
  input  logic [IDX_W-1:0] cmp_idx,
  input  logic             ent_vld,
  input  logic [VID_W-1:0] ent_vid,
  input  logic [VID_W-1:0] key,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic             free_found,
  output logic [IDX_W-1:0] free_idx,
  output logic             nxt_found,
  output logic [IDX_W-1:0] nxt_idx,
  output logic [VID_W-1:0] nxt_vid
);
  logic take_nxt;
  assign take_nxt = ent_vld && (ent_vid > key) && (!nxt_found || ent_vid < nxt_vid);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      hit        <= 1'b0;
      hit_idx    <= '0;
      free_found <= 1'b0;
      free_idx   <= '0;
      nxt_found  <= 1'b0;
      nxt_idx    <= '0;
      nxt_vid    <= '0;
    end else if (cmp_en) begin
      if (ent_vld && ent_vid == key && !hit) begin
        hit     <= 1'b1;
        hit_idx <= cmp_idx;
      end
      if (!ent_vld && !free_found) begin
        free_found <= 1'b1;
        free_idx   <= cmp_idx;
      end
      if (take_nxt) begin
        nxt_found <= 1'b1;
        nxt_idx   <= cmp_idx;
        nxt_vid   <= ent_vid;
      end
    end
  end

  // the running candidate always lies strictly above the key it was scanned against
  assert_next_above_key_R3: assert property (@(posedge clk) disable iff (rst)
    (cmp_en && !clear && $stable(key)) |=> (!nxt_found || nxt_vid > key));
  // the candidate never grows during one scan
  assert_next_shrinks_R3: assert property (@(posedge clk) disable iff (rst)
    (cmp_en && !clear && nxt_found) |=> (nxt_vid <= $past(nxt_vid)));
endmodule

// File: rtl/vtbl_pack.sv
module vtbl_pack #(
  parameter int NUM_PORTS = 10,
  localparam int MEM_W = 2 * NUM_PORTS
) (
  input  logic [MEM_W-1:0]                           mem_in,
  output logic [vtbl_pkg::NUM_DREG-1:0][vtbl_pkg::REG_W-1:0] dreg_out
);
  // member tags go back to their slots; port state bits stay zero
  always_comb begin
    dreg_out = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      dreg_out[i / 4][(i % 4) * 4 +: 2] = mem_in[2 * i +: 2];
    end
  end
endmodule

// File: rtl/vlan_tbl_engine.sv
module vlan_tbl_engine #(
  parameter int NUM_PORTS = 10,
  parameter int DEPTH     = 64,
  parameter int DB_W      = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata
);
  import vtbl_pkg::*;

  localparam int IDX_W = $clog2(DEPTH);
  localparam int MEM_W = 2 * NUM_PORTS;
  localparam int ENT_W = VID_W + MEM_W + DB_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  eng_st_e st;
  logic [REG_W-1:0]               cmd_q, id_q;
  logic [NUM_DREG-1:0][REG_W-1:0] dreg_q;
  logic [IDX_W-1:0]               sc;
  logic                           cmp_en_q;
  logic [IDX_W-1:0]               cmp_idx_q;

  logic busy;
  assign busy = cmd_q[15];
  logic [2:0] code;
  assign code = cmd_q[14:12];

  logic host_ok, go;
  assign host_ok = reg_wr && !busy;
  assign go = host_ok && reg_addr == ADR_CMD && reg_wdata[15];
  logic scan_go;
  assign scan_go = go && (reg_wdata[14:12] == CODE_STORE || reg_wdata[14:12] == CODE_WALK);

  // unpack member tags from the data words
  logic [MEM_W-1:0] ld_mem;
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_unpack
    assign ld_mem[2 * i +: 2] = dreg_q[i / 4][(i % 4) * 4 +: 2];
  end

  logic [7:0]      db_full;
  logic [DB_W-1:0] ld_db;
  assign db_full = {cmd_q[11:8], cmd_q[3:0]};
  assign ld_db   = db_full[DB_W-1:0];

  // store and scan plumbing
  logic [IDX_W-1:0] rd_addr;
  logic [ENT_W-1:0] rd_ent, wr_ent;
  logic             rd_vld;
  logic             wr_en, clr_en, flush;
  logic [IDX_W-1:0] wr_addr;
  logic             hit, free_found, nxt_found;
  logic [IDX_W-1:0] hit_idx, free_idx, nxt_idx;
  logic [VID_W-1:0] nxt_vid;

  logic commit_store;
  assign commit_store = (st == ST_COMMIT) && (code == CODE_STORE);
  assign rd_addr = (st == ST_FETCH) ? nxt_idx : sc;
  assign wr_ent  = {ld_db, ld_mem, id_q[VID_W-1:0]};
  assign wr_en   = commit_store && id_q[15] && (hit || free_found);
  assign wr_addr = hit ? hit_idx : free_idx;
  assign clr_en  = commit_store && !id_q[15] && hit;
  assign flush   = (st == ST_COMMIT) && (code == CODE_CLEAR);

  vtbl_store #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_store (
    .clk(clk), .rst(rst),
    .rd_addr(rd_addr), .rd_ent(rd_ent), .rd_vld(rd_vld),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_ent(wr_ent),
    .clr_en(clr_en), .clr_addr(hit_idx), .flush(flush)
  );

  vtbl_match #(.IDX_W(IDX_W), .VID_W(VID_W)) u_match (
    .clk(clk), .rst(rst), .clear(scan_go),
    .cmp_en(cmp_en_q), .cmp_idx(cmp_idx_q),
    .ent_vld(rd_vld), .ent_vid(rd_ent[VID_W-1:0]), .key(id_q[VID_W-1:0]),
    .hit(hit), .hit_idx(hit_idx),
    .free_found(free_found), .free_idx(free_idx),
    .nxt_found(nxt_found), .nxt_idx(nxt_idx), .nxt_vid(nxt_vid)
  );

  logic [DB_W-1:0] rb_db;
  logic [7:0]      rb_db8;
  logic [NUM_DREG-1:0][REG_W-1:0] rb_dreg;
  assign rb_db  = rd_ent[VID_W + MEM_W +: DB_W];
  assign rb_db8 = 8'(rb_db);

  vtbl_pack #(.NUM_PORTS(NUM_PORTS)) u_pack (
    .mem_in(rd_ent[VID_W +: MEM_W]), .dreg_out(rb_dreg)
  );

  // sequencer and register file
  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cmd_q     <= '0;
      id_q      <= '0;
      dreg_q    <= '0;
      sc        <= '0;
      cmp_en_q  <= 1'b0;
      cmp_idx_q <= '0;
    end else begin
      cmp_en_q  <= (st == ST_SCAN);
      cmp_idx_q <= sc;
      if (host_ok) begin
        case (reg_addr)
          ADR_CMD: cmd_q     <= reg_wdata;
          ADR_ID:  id_q      <= reg_wdata;
          ADR_D0:  dreg_q[0] <= reg_wdata;
          ADR_D1:  dreg_q[1] <= reg_wdata;
          ADR_D2:  dreg_q[2] <= reg_wdata;
          default: ;
        endcase
      end
      case (st)
        ST_IDLE: begin
          if (go) begin
            sc <= '0;
            st <= scan_go ? ST_SCAN : ST_COMMIT;
          end
        end
        ST_SCAN: begin
          if (sc == LAST) st <= ST_DRAIN;
          else            sc <= sc + 1'b1;
        end
        ST_DRAIN: st <= (code == CODE_WALK) ? ST_FETCH : ST_COMMIT;
        ST_FETCH: st <= ST_COMMIT;
        ST_COMMIT: begin
          cmd_q[15] <= 1'b0;
          if (code == CODE_WALK) begin
            if (nxt_found) begin
              id_q        <= {1'b1, {(REG_W - VID_W - 1){1'b0}}, nxt_vid};
              dreg_q      <= rb_dreg;
              cmd_q[11:8] <= rb_db8[7:4];
              cmd_q[3:0]  <= rb_db8[3:0];
            end else begin
              id_q[15] <= 1'b0;
            end
          end
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        ADR_CMD: reg_rdata <= cmd_q;
        ADR_ID:  reg_rdata <= id_q;
        ADR_D0:  reg_rdata <= dreg_q[0];
        ADR_D1:  reg_rdata <= dreg_q[1];
        ADR_D2:  reg_rdata <= dreg_q[2];
        default: reg_rdata <= '0;
      endcase
    end
  end

  assert_start_sets_busy_R1: assert property (@(posedge clk) disable iff (rst)
    go |=> busy);
  assert_busy_holds_R1: assert property (@(posedge clk) disable iff (rst)
    (busy && st != ST_COMMIT) |=> busy);
  assert_busy_self_clears_R1: assert property (@(posedge clk) disable iff (rst)
    (st == ST_COMMIT) |=> !busy);
  assert_locked_regs_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && st != ST_COMMIT) |=> ($stable(id_q) && $stable(dreg_q) && $stable(cmd_q)));
  assert_scan_steps_R12: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SCAN && sc != LAST) |=> (st == ST_SCAN && sc == $past(sc) + 1'b1));
  assert_no_dual_update_R6: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && clr_en));
endmodule

// File: tb/tb_vlan_tbl_engine.sv
module tb_vlan_tbl_engine;
  localparam int CLK_T = 10;
  localparam int DEPTH = 64;
  localparam int NP    = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;

  int total = 0;
  int bad = 0;

  vlan_tbl_engine #(.NUM_PORTS(NP), .DEPTH(DEPTH), .DB_W(8)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #(CLK_T / 2) clk = ~clk;

  // reference model indexed by ID
  bit         mvalid [8192];
  logic [7:0] mdb    [8192];
  logic [19:0] mmem  [8192];
  int mcnt = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  // start a command and count the cycles the busy flag reads 1
  task automatic run_op(input logic [15:0] opw, output int cnt);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = opw;
    @(negedge clk);
    reg_wr = 1'b0;
    cnt = 0;
    for (int g = 0; g < 2000; g++) begin
      @(negedge clk);
      if (!reg_rdata[15]) break;
      cnt++;
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    reg_addr = 3'd0;
    for (int g = 0; g < 2000; g++) begin
      @(negedge clk);
      if (!reg_rdata[15]) break;
    end
  endtask

  function automatic logic [47:0] pack_exp(input logic [19:0] m, input bit with_state);
    logic [47:0] r = '0;
    for (int i = 0; i < NP; i++) begin
      r[(i / 4) * 16 + (i % 4) * 4 +: 2] = m[2 * i +: 2];
      if (with_state) r[(i / 4) * 16 + (i % 4) * 4 + 2 +: 2] = 2'((i + 1) % 4);
    end
    return r;
  endfunction

  function automatic logic [15:0] cmd_word(input logic [2:0] c, input logic [7:0] db);
    return {1'b1, c, db[7:4], 4'h0, db[3:0]};
  endfunction

  function automatic int mnext(input int key);
    for (int v = key + 1; v < 8192; v++) if (mvalid[v]) return v;
    return -1;
  endfunction

  function automatic logic [19:0] pattern(input int j);
    logic [19:0] m;
    for (int i = 0; i < NP; i++) m[2 * i +: 2] = 2'((i + j) % 4);
    return m;
  endfunction

  task automatic store(input int vid, input logic [7:0] db, input logic [19:0] m,
                       input bit st_fill, output int cnt);
    logic [47:0] d = pack_exp(m, st_fill);
    wr(3'd2, d[15:0]); wr(3'd3, d[31:16]); wr(3'd4, d[47:32]);
    wr(3'd1, 16'h8000 | 16'(vid));
    run_op(cmd_word(3'd3, db), cnt);
    if (mvalid[vid] || mcnt < DEPTH) begin
      if (!mvalid[vid]) mcnt++;
      mvalid[vid] = 1'b1; mdb[vid] = db; mmem[vid] = m;
    end
  endtask

  task automatic purge(input int vid);
    int c;
    wr(3'd1, 16'(vid));
    run_op(cmd_word(3'd3, 8'h00), c);
    if (mvalid[vid]) begin mvalid[vid] = 1'b0; mcnt--; end
  endtask

  task automatic clear_all(output int cnt);
    run_op(cmd_word(3'd1, 8'h00), cnt);
    for (int v = 0; v < 8192; v++) mvalid[v] = 1'b0;
    mcnt = 0;
  endtask

  // walk the whole table from key 0 and compare every step to the model
  task automatic walk(input string tag, input bit chk_len);
    int key = 0;
    int steps = 0;
    int c, e;
    logic [15:0] v, op, d0, d1, d2;
    logic [47:0] ex;
    wr(3'd1, 16'h0000);
    for (int s = 0; s < DEPTH + 2; s++) begin
      run_op(cmd_word(3'd4, 8'h00), c);
      if (chk_len && s == 0) chk({tag, " R12 walk busy"}, c, DEPTH + 3);
      rd(3'd1, v);
      e = mnext(key);
      if (e < 0) begin
        chk({tag, " R4 valid cleared"}, v[15], 1'b0);
        chk({tag, " R4 key kept"}, v[12:0], key);
        break;
      end
      chk({tag, " R3 R5 next id"}, v, 16'h8000 | 16'(e));
      rd(3'd0, op);
      chk({tag, " R9 db fields"}, {op[11:8], op[3:0]}, mdb[e]);
      chk({tag, " R1 busy low"}, op[15], 1'b0);
      rd(3'd2, d0); rd(3'd3, d1); rd(3'd4, d2);
      ex = pack_exp(mmem[e], 1'b0);
      chk({tag, " R8 data words"}, {d2, d1, d0}, ex);
      key = e;
      steps++;
    end
    chk({tag, " R5 entry count"}, steps, mcnt);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c;
    logic [15:0] v;
    for (int v2 = 0; v2 < 8192; v2++) mvalid[v2] = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset contents
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1 reset value", v, 16'h0000);
    end

    clear_all(c);
    chk("R12 clear busy", c, 1);

    // R6 R8 R9: varied IDs incl. bit 12, extremes, with state bits on odd entries
    begin
      int ids[6] = '{12'hFFF, 13'h1005, 1, 12'h800, 13'h1FFF, 16};
      for (int j = 0; j < 6; j++) begin
        store(ids[j], 8'((j * 37 + 5) & 8'hFF), pattern(j), j % 2 == 1, c);
        if (j == 0) chk("R12 store busy", c, DEPTH + 2);
      end
    end
    walk("first walk", 1'b1);

    // R6: replace existing entry
    store(12'h800, 8'hA5, pattern(3), 1'b1, c);
    walk("R6 replace", 1'b0);

    // R7: remove present and absent IDs
    purge(13'h1005);
    purge(12'h222);
    walk("R7 remove", 1'b0);

    // R2: writes during busy are ignored
    begin
      logic [47:0] d = pack_exp(pattern(2), 1'b0);
      logic [15:0] r;
      wr(3'd2, d[15:0]); wr(3'd3, d[31:16]); wr(3'd4, d[47:32]);
      wr(3'd1, 16'h8000 | 16'h0333);
      wr(3'd0, cmd_word(3'd3, 8'h3C));
      wr(3'd1, 16'h8000 | 16'h0444);
      wr(3'd2, 16'hFFFF);
      wr(3'd0, cmd_word(3'd4, 8'h00));
      wait_idle();
      mvalid[12'h333] = 1'b1; mdb[12'h333] = 8'h3C; mmem[12'h333] = pattern(2); mcnt++;
      rd(3'd1, r); chk("R2 id kept", r, 16'h8333);
      rd(3'd2, r); chk("R2 data kept", r, d[15:0]);
      rd(3'd0, r); chk("R2 command kept", r, cmd_word(3'd3, 8'h3C) & 16'h7FFF);
      walk("R2 locked", 1'b0);
    end

    // R10: clear empties the table
    clear_all(c);
    chk("R10 R12 clear busy", c, 1);
    walk("R10 after clear", 1'b0);

    // R11: fill all slots, then one more new ID is dropped
    for (int j = 0; j < DEPTH; j++) store(100 + 3 * j, 8'(j), pattern(j), 1'b0, c);
    store(5, 8'h77, pattern(1), 1'b0, c);
    chk("R11 model full", mcnt, DEPTH);
    walk("R11 full table", 1'b0);
    // replacing inside a full table still works
    store(100, 8'hEE, pattern(7), 1'b0, c);
    walk("R6 R11 replace when full", 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule